// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles a processor places on a parallel NOR flash bus and turns recognised multi-cycle command sequences into control actions. A sequence is accepted only after a two-write unlock prefix. The third write carries the command byte. Depending on that byte, the decoder points the read path at the memory array, the identifier codes or the status register. It can also capture a program target and raise a program request, or collect the second unlock prefix of a chip erase and raise an erase request to the internal write engine.

While the write engine is running, the decoder narrows what it will respond to. During a program it takes no commands at all. During an erase it accepts only a single-write suspend byte. When the engine reports completion, the read path stays on the status register until the processor writes a new valid sequence. In identifier mode the block also supplies the manufacturer and device codes for reads at the two identifier addresses. The flash array, the program and erase algorithms and all analog timing lie outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_sel is 0 (array), id_data is 0x00, and the outputs prog_req, erase_req, suspend_req and clr_stat are all low.
- R2: A valid sequence is 0xAA written to command address 0x5555, then 0x55 written to 0x2AAA, then a command byte written to 0x5555. Byte 0xF0 sets rd_sel to 0 (array) and byte 0x90 sets rd_sel to 1 (identifier). The change is visible in the cycle after the third write.
- R3: After byte 0xA0, the next write of any kind is the program cycle. That write captures the full 20-bit address into prog_addr and the full 16-bit data into prog_data, raises prog_req for exactly one cycle and sets rd_sel to 2 (status).
- R4: Byte 0x80 followed by a second unlock prefix and then 0x10 written to 0x5555 raises erase_req for exactly one cycle and sets rd_sel to 2.
- R5: Byte 0x70 sets rd_sel to 2. Byte 0x50 raises clr_stat for one cycle and leaves rd_sel unchanged.
- R6: Sequence decoding compares only address bits 14..0 and data bits 7..0. Address bits 19..15 and data bits 15..8 have no effect.
- R7: A write that breaks the expected prefix, or a third-write byte outside {0xF0, 0x90, 0xA0, 0x80, 0x70, 0x50}, sets rd_sel to 0 and raises no request. At most one of the four request pulses is high in any cycle.
- R8: While a program is in progress (from prog_req until eng_done), every write is ignored: no pulse is raised and rd_sel stays at 2.
- R9: While an erase is in progress and eng_busy is high, a write whose low byte is 0xB0, at any address and with no prefix, raises suspend_req for one cycle. Other writes during the erase are ignored, and 0xB0 raises nothing while eng_busy is low.
- R10: When eng_done is seen, rd_sel remains 2 through any number of cycles and reads until a new valid sequence selects another mode.
- R11: A read strobe while rd_sel is 1 loads id_data, one cycle later, with 0xC2 for address bits 14..0 equal to 0, 0x6B for 1, and 0x00 otherwise. A read strobe in any other mode loads 0x00. Without a read strobe, id_data holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | 20 | Bus address |
| wdata | input | 16 | Bus write data |
| eng_busy | input | 1 | Write engine is running |
| eng_done | input | 1 | Write engine finished (pulse) |
| rd_sel | output | 2 | Read path: 0 array, 1 identifier, 2 status |
| id_data | output | 8 | Identifier code for the last read |
| prog_req | output | 1 | Program request pulse |
| erase_req | output | 1 | Chip erase request pulse |
| suspend_req | output | 1 | Erase suspend pulse |
| clr_stat | output | 1 | Clear status pulse |
| prog_addr | output | 20 | Captured program address |
| prog_data | output | 16 | Captured program data |

## Verification
The third-write byte is swept over all 256 values after a clean prefix. This separates the six recognised codes from every unknown byte, which must fall back to array mode without any request. The identifier sequence is replayed with each combination of the five ignored high address bits and with random upper data bytes, which shows that only the low fields take part in decoding. Program and erase runs are driven with full prefixes, stray bytes and suspend bytes while the engine reports busy. This distinguishes the program lockout from the erase case where suspend is allowed, and shows that status mode persists after completion.

// File: rtl/fcd_pkg.sv
// Package: shared encodings for the flash command sequence decoder.
// Assumes command decoding uses an 8-bit command byte.
package fcd_pkg;

    // Read path selection driven to the data-out mux.
    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_IDENT  = 2'd1,
        SEL_STATUS = 2'd2
    } rd_sel_e;

    // Sequence recogniser states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_WAIT,
        ST_ERS_UNL0,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_BUSY_PGM,
        ST_BUSY_ERS
    } seq_state_e;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] OP_READ     = 8'hF0;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERS_SET  = 8'h80;
    localparam logic [7:0] OP_ERS_CHIP = 8'h10;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_SUSPEND  = 8'hB0;

    localparam logic [7:0] MFR_CODE    = 8'hC2;
    localparam logic [7:0] DEV_CODE    = 8'h6B;

endpackage

// File: rtl/fcd_seq.sv
// Module: fcd_seq
// Recognises unlock-prefixed command sequences from write cycles and
// tracks the write-engine busy phases. Request outputs are registered
// one-cycle pulses; take_pgm is a combinational capture strobe asserted
// in the same cycle as the program write.
// Assumes wr_en is a single-cycle strobe per bus write.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int          CMD_W   = 15,
    parameter logic [14:0] ADDR_LO = 15'h5555,
    parameter logic [14:0] ADDR_HI = 15'h2AAA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] cmd_addr,
    input  logic [7:0]       cmd_byte,
    input  logic             eng_busy,
    input  logic             eng_done,
    output rd_sel_e          sel,
    output logic             take_pgm,
    output logic             prog_pulse,
    output logic             erase_pulse,
    output logic             susp_pulse,
    output logic             clr_pulse
);

    seq_state_e state, state_n;
    rd_sel_e    sel_n;
    logic       prog_n, erase_n, susp_n, clr_n;
    logic       at_lo, at_hi;

    // Compare the command address against the two unlock locations.
    assign at_lo = (cmd_addr == ADDR_LO[CMD_W-1:0]);
    assign at_hi = (cmd_addr == ADDR_HI[CMD_W-1:0]);

    // Next-state and request decode for one write cycle.
    always_comb begin
        state_n  = state;
        sel_n    = sel;
        prog_n   = 1'b0;
        erase_n  = 1'b0;
        susp_n   = 1'b0;
        clr_n    = 1'b0;
        take_pgm = 1'b0;
        case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    if (at_lo && cmd_byte == KEY_FIRST) begin
                        state_n = ST_UNL1;
                    end else begin
                        sel_n = SEL_ARRAY;
                    end
                end
            end
            ST_UNL1: begin
                if (wr_en) begin
                    if (at_hi && cmd_byte == KEY_SECOND) begin
                        state_n = ST_UNL2;
                    end else begin
                        state_n = ST_IDLE;
                        sel_n   = SEL_ARRAY;
                    end
                end
            end
            ST_UNL2: begin
                if (wr_en) begin
                    state_n = ST_IDLE;
                    if (!at_lo) begin
                        sel_n = SEL_ARRAY;
                    end else begin
                        case (cmd_byte)
                            OP_READ:    sel_n = SEL_ARRAY;
                            OP_IDENT:   sel_n = SEL_IDENT;
                            OP_STATUS:  sel_n = SEL_STATUS;
                            OP_CLEAR:   clr_n = 1'b1;
                            OP_PROGRAM: state_n = ST_PGM_WAIT;
                            OP_ERS_SET: state_n = ST_ERS_UNL0;
                            default:    sel_n = SEL_ARRAY;
                        endcase
                    end
                end
            end
            ST_PGM_WAIT: begin
                if (wr_en) begin
                    take_pgm = 1'b1;
                    prog_n   = 1'b1;
                    sel_n    = SEL_STATUS;
                    state_n  = ST_BUSY_PGM;
                end
            end
            ST_ERS_UNL0: begin
                if (wr_en) begin
                    if (at_lo && cmd_byte == KEY_FIRST) begin
                        state_n = ST_ERS_UNL1;
                    end else begin
                        state_n = ST_IDLE;
                        sel_n   = SEL_ARRAY;
                    end
                end
            end
            ST_ERS_UNL1: begin
                if (wr_en) begin
                    if (at_hi && cmd_byte == KEY_SECOND) begin
                        state_n = ST_ERS_UNL2;
                    end else begin
                        state_n = ST_IDLE;
                        sel_n   = SEL_ARRAY;
                    end
                end
            end
            ST_ERS_UNL2: begin
                if (wr_en) begin
                    if (at_lo && cmd_byte == OP_ERS_CHIP) begin
                        erase_n = 1'b1;
                        sel_n   = SEL_STATUS;
                        state_n = ST_BUSY_ERS;
                    end else begin
                        state_n = ST_IDLE;
                        sel_n   = SEL_ARRAY;
                    end
                end
            end
            ST_BUSY_PGM: begin
                sel_n = SEL_STATUS;
                if (eng_done) begin
                    state_n = ST_IDLE;
                end
            end
            ST_BUSY_ERS: begin
                sel_n = SEL_STATUS;
                if (eng_done) begin
                    state_n = ST_IDLE;
                end else if (wr_en && eng_busy && cmd_byte == OP_SUSPEND) begin
                    susp_n = 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                sel_n   = SEL_ARRAY;
            end
        endcase
    end

    // Register state, read selection and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            sel         <= SEL_ARRAY;
            prog_pulse  <= 1'b0;
            erase_pulse <= 1'b0;
            susp_pulse  <= 1'b0;
            clr_pulse   <= 1'b0;
        end else begin
            state       <= state_n;
            sel         <= sel_n;
            prog_pulse  <= prog_n;
            erase_pulse <= erase_n;
            susp_pulse  <= susp_n;
            clr_pulse   <= clr_n;
        end
    end

endmodule

// File: rtl/fcd_prog_latch.sv
// Module: fcd_prog_latch
// Holds the full program target address and data word, loaded when
// the sequence recogniser signals the program write cycle.
// Assumes capture is a single-cycle strobe.
module fcd_prog_latch #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    // Load target address and data on the program write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/fcd_id_read.sv
// Module: fcd_id_read
// Returns the manufacturer or device identifier for a read strobe while
// identifier mode is active; other reads load zero.
// Assumes the identifier locations are command-address offsets 0 and 1.
module fcd_id_read
    import fcd_pkg::*;
#(
    parameter int CMD_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             ident_mode,
    input  logic [CMD_W-1:0] id_addr,
    output logic [7:0]       id_q
);

    logic [7:0] code;

    // Pick the identifier byte for the presented offset.
    always_comb begin
        if (!ident_mode) begin
            code = 8'h00;
        end else if (id_addr == CMD_W'(0)) begin
            code = MFR_CODE;
        end else if (id_addr == CMD_W'(1)) begin
            code = DEV_CODE;
        end else begin
            code = 8'h00;
        end
    end

    // Register the identifier byte on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= 8'h00;
        end else if (rd_en) begin
            id_q <= code;
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: flash_cmd_decoder
// Top of the flash command sequence decoder: splits the bus into the
// decoded command fields, recognises sequences, captures the program
// target and serves identifier reads.
// Assumes one bus operation per strobe and a single clock domain.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CMD_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic [1:0]        rd_sel,
    output logic [7:0]        id_data,
    output logic              prog_req,
    output logic              erase_req,
    output logic              suspend_req,
    output logic              clr_stat,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);

    localparam int BYTE_W = 8;

    logic [CMD_W-1:0]  cmd_addr;
    logic [BYTE_W-1:0] cmd_byte;
    rd_sel_e           sel;
    logic              take_pgm;

    assign cmd_addr = addr[CMD_W-1:0];
    assign cmd_byte = wdata[BYTE_W-1:0];
    assign rd_sel   = sel;

    fcd_seq #(
        .CMD_W (CMD_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .cmd_addr    (cmd_addr),
        .cmd_byte    (cmd_byte),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .sel         (sel),
        .take_pgm    (take_pgm),
        .prog_pulse  (prog_req),
        .erase_pulse (erase_req),
        .susp_pulse  (suspend_req),
        .clr_pulse   (clr_stat)
    );

    fcd_prog_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (take_pgm),
        .addr_in (addr),
        .data_in (wdata),
        .addr_q  (prog_addr),
        .data_q  (prog_data)
    );

    fcd_id_read #(
        .CMD_W (CMD_W)
    ) u_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .ident_mode (sel == SEL_IDENT),
        .id_addr    (cmd_addr),
        .id_q       (id_data)
    );

endmodule

// File: rtl/fcd_checker.sv
// Module: fcd_checker
// Temporal checks on the decoder ports, attached by bind.
module fcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wbyte,
    input logic [1:0] rd_sel,
    input logic [7:0] id_data,
    input logic       prog_req,
    input logic       erase_req,
    input logic       suspend_req,
    input logic       clr_stat
);

    // R3
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R3
    prog_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (rd_sel == 2'd2) && $past(wr_en));

    // R4
    erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (rd_sel == 2'd2) && $past(wr_en));

    // R7
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, suspend_req, clr_stat}));

    // R9
    suspend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> $past(wr_en) && ($past(wbyte) == 8'hB0) && (rd_sel == 2'd2));

    // R5
    clear_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |-> $stable(rd_sel));

    // R11
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(id_data));

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wbyte       (wdata[7:0]),
    .rd_sel      (rd_sel),
    .id_data     (id_data),
    .prog_req    (prog_req),
    .erase_req   (erase_req),
    .suspend_req (suspend_req),
    .clr_stat    (clr_stat)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic [1:0]  rd_sel;
    logic [7:0]  id_data;
    logic        prog_req, erase_req, suspend_req, clr_stat;
    logic [19:0] prog_addr;
    logic [15:0] prog_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .eng_busy(eng_busy), .eng_done(eng_done),
        .rd_sel(rd_sel), .id_data(id_data), .prog_req(prog_req),
        .erase_req(erase_req), .suspend_req(suspend_req), .clr_stat(clr_stat),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h, expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pulses();
        return {prog_req, erase_req, suspend_req, clr_stat};
    endfunction

    // Inputs change on the falling edge; outputs are read just before the next rising edge.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; eng_busy = 1'b0; eng_done = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic prefix(input logic [19:0] hi);
        wr(hi | 20'h05555, 16'h00AA);
        wr(hi | 20'h02AAA, 16'h0055);
    endtask

    task automatic done_pulse();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        eng_busy = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 rd_sel", rd_sel, 0);
        check("R1 id_data", id_data, 0);
        check("R1 pulses", pulses(), 0);

        // R7 / R2 / R5 sweep of every third-write byte
        for (int b = 0; b < 256; b++) begin
            logic [1:0] es;
            logic [3:0] ep;
            do_reset();
            wr(20'h05555, 16'h00AA);
            wr(20'h02AAA, 16'h0055);
            wr(20'h05555, 16'(b));
            es = (b == 8'h90) ? 2'd1 : (b == 8'h70) ? 2'd2 : 2'd0;
            ep = (b == 8'h50) ? 4'b0001 : 4'b0000;
            check("R7 sweep rd_sel", rd_sel, es);
            check("R7 sweep pulses", pulses(), ep);
        end

        // R6 high address bits and upper data byte ignored
        for (int h = 0; h < 32; h++) begin
            do_reset();
            wr(20'(h) << 15 | 20'h05555, {8'(h * 7 + 3), 8'hAA});
            wr(20'(h) << 15 | 20'h02AAA, {8'(h * 13), 8'h55});
            wr(20'(h) << 15 | 20'h05555, {8'(~h), 8'h90});
            check("R6 ident via high bits", rd_sel, 1);
        end

        // R11 identifier reads
        rd(20'h00000); check("R11 mfr code", id_data, 8'hC2);
        idle(2);       check("R11 hold", id_data, 8'hC2);
        rd(20'h00001); check("R11 dev code", id_data, 8'h6B);
        rd(20'h00002); check("R11 other", id_data, 8'h00);
        rd(20'h88001); check("R11 high bits", id_data, 8'h6B);
        prefix(0); wr(20'h05555, 16'h00F0);
        check("R2 back to array", rd_sel, 0);
        rd(20'h00000); check("R11 not ident", id_data, 8'h00);

        // R7 broken prefix
        do_reset();
        wr(20'h05555, 16'h00AA); wr(20'h02AAB, 16'h0055); wr(20'h05555, 16'h0090);
        check("R7 bad second addr", rd_sel, 0);
        prefix(0); wr(20'h05554, 16'h0070);
        check("R7 bad third addr", rd_sel, 0);
        prefix(0); wr(20'h05555, 16'h0070);
        check("R5 status", rd_sel, 2);
        wr(20'h01234, 16'h00AB);
        check("R7 stray write", rd_sel, 0);
        prefix(0); wr(20'h05555, 16'h0070);
        prefix(0); wr(20'h05555, 16'h0050);
        check("R5 clear pulse", clr_stat, 1);
        check("R5 clear keeps sel", rd_sel, 2);
        idle(1); check("R5 clear one cycle", clr_stat, 0);

        // R3 program, R8 lockout, R10 status persists
        do_reset();
        prefix(0); wr(20'h05555, 16'h00A0);
        check("R3 no early req", prog_req, 0);
        wr(20'hABCDE, 16'hBEEF);
        check("R3 prog_req", prog_req, 1);
        check("R3 prog_addr", prog_addr, 20'hABCDE);
        check("R3 prog_data", prog_data, 16'hBEEF);
        check("R3 status sel", rd_sel, 2);
        eng_busy = 1'b1;
        idle(1); check("R3 pulse width", prog_req, 0);
        prefix(0); wr(20'h05555, 16'h00F0);
        check("R8 sel locked", rd_sel, 2);
        prefix(0); wr(20'h05555, 16'h00A0); wr(20'h11111, 16'h2222);
        check("R8 no pulse", pulses(), 0);
        check("R8 addr kept", prog_addr, 20'hABCDE);
        wr(20'h00000, 16'h00B0);
        check("R8 no suspend", suspend_req, 0);
        done_pulse();
        idle(5); rd(20'h00000);
        check("R10 status persists", rd_sel, 2);
        prefix(0); wr(20'h05555, 16'h0090);
        check("R10 new command", rd_sel, 1);

        // R4 chip erase, R9 suspend
        do_reset();
        prefix(0); wr(20'h05555, 16'h0080);
        prefix(20'h40000); wr(20'h05555, 16'h0010);
        check("R4 erase_req", erase_req, 1);
        check("R4 status sel", rd_sel, 2);
        eng_busy = 1'b1;
        idle(1); check("R4 pulse width", erase_req, 0);
        prefix(0); wr(20'h05555, 16'h0090);
        check("R9 other ignored", rd_sel, 2);
        wr(20'h00123, 16'hFFB0);
        check("R9 suspend", suspend_req, 1);
        idle(1); check("R9 suspend width", suspend_req, 0);
        eng_busy = 1'b0;
        wr(20'h00123, 16'h00B0);
        check("R9 suspend needs busy", suspend_req, 0);
        done_pulse();
        check("R10 after erase", rd_sel, 2);

        // R4 broken second prefix
        do_reset();
        prefix(0); wr(20'h05555, 16'h0080);
        prefix(0); wr(20'h05555, 16'h0030);
        check("R4 bad erase byte", pulses(), 0);
        check("R7 bad erase sel", rd_sel, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule